// File: doc/BRIEF.md
# Strided Cache Line Walker

The walker turns a rectangle inside a framebuffer into the list of cache-line addresses that cover it, so that a cache clean or invalidate can be issued once for each line. The rectangle is described by a byte start address, a pixel size in bytes, a row width in pixels, a number of pixels skipped between rows, and a row count. After a start pulse, the walker visits the rows in order. For each row it sends the line-aligned addresses that overlap the bytes of that row. The walker itself performs no cache maintenance.

Addresses leave on a valid/ready stream. An address is presented with `line_valid` and stays unchanged until the consumer accepts it by raising `line_ready` in the same cycle. Stalls can last any number of cycles, and the walker does not advance while it is stalled. `done` pulses for one cycle when the walk ends. Two rows often share a cache line, for example when the rows are narrow or the skip is small. In that case a row starts no lower than the line that follows the last line already issued, so no line is sent twice. When the cache is disabled, or the rectangle is empty, the walk finishes at once and sends nothing.

Top module: `cache_line_walker`

## Requirements
- R1: Every emitted address is a multiple of LINE_BYTES (default 32), meaning its low log2(LINE_BYTES) bits are zero.
- R2: Row r, counting from 0, starts at byte `base_addr + r * pix_bytes * (width_px + skip_px)`.
- R3: Each row covers bytes from its start up to, but not including, start + `pix_bytes * width_px`. Its lines run from the row start aligned down, in steps of LINE_BYTES, for as long as the line address is below that end.
- R4: If the aligned start of a row is below the line after the last line the walk has emitted so far, it is raised to that line. A row can therefore emit nothing. The addresses of one walk strictly increase and never repeat.
- R5: A start with `cache_en` low emits no address. `done` is high in the cycle after the start, and `busy` stays low.
- R6: A start with `width_px`, `height_ln` or `pix_bytes` equal to zero emits no address. `done` is high in the cycle after the start.
- R7: `done` is a single-cycle pulse. It rises only after every address of the walk has been accepted. When the last row emits a line, `done` is high in the cycle right after the final acceptance.
- R8: While `line_valid` is high and `line_ready` is low, `line_valid` stays high and `line_addr` holds its value. `line_valid` is never high while `busy` is low.
- R9: A start pulse while `busy` is high is ignored. The running walk continues unchanged and produces one `done`.
- R10: After an accepted start of a non-empty walk, `busy` is high from the next cycle until the cycle in which `done` is high. In that cycle `busy` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk; sampled only when idle |
| cache_en | input | 1 | Cache enabled; when low a start completes with no output |
| base_addr | input | ADDR_W | Byte address of the first pixel |
| width_px | input | DIM_W | Pixels per row |
| skip_px | input | DIM_W | Pixels skipped between the end of one row and the start of the next |
| height_ln | input | DIM_W | Number of rows |
| pix_bytes | input | PSZ_W | Bytes per pixel |
| line_valid | output | 1 | A cache-line address is offered |
| line_ready | input | 1 | Consumer accepts the offered address |
| line_addr | output | ADDR_W | Line-aligned address |
| done | output | 1 | One-cycle pulse at the end of a walk |
| busy | output | 1 | A walk is in progress |

## Verification
The properties assume that the rectangle does not wrap past the top of the address space, because the strictly-increasing order of R4 depends on that. The bench therefore uses base addresses in the low pages and pixel sizes of at most four bytes. The properties also assume that the configuration inputs are held only for the start cycle. The design captures them there, and the bench changes them freely afterwards, including during a rejected start, to show that they are not reread. Back-pressure is applied both as a steady ready and as a pseudo-random ready, so that the hold rule of R8 is exercised with stalls of varying length.

// File: rtl/wcw_pkg.sv
package wcw_pkg;
  typedef enum logic [1:0] {
    WS_IDLE = 2'd0,
    WS_ROW  = 2'd1,
    WS_EMIT = 2'd2
  } walk_state_t;
endpackage

// File: rtl/wcw_geom.sv
module wcw_geom #(
  parameter int DIM_W  = 16,
  parameter int PSZ_W  = 3,
  parameter int SPAN_W = DIM_W + 1 + PSZ_W
) (
  input  logic [DIM_W-1:0]  width_px,
  input  logic [DIM_W-1:0]  skip_px,
  input  logic [PSZ_W-1:0]  pix_bytes,
  output logic [SPAN_W-1:0] stride_bytes,
  output logic [SPAN_W-1:0] len_bytes
);
  // Byte distance between row starts, and bytes actually covered per row.
  always_comb begin
    stride_bytes = SPAN_W'(pix_bytes) * (SPAN_W'(width_px) + SPAN_W'(skip_px));
    len_bytes    = SPAN_W'(pix_bytes) * SPAN_W'(width_px);
  end
endmodule

// File: rtl/wcw_row_plan.sv
module wcw_row_plan #(
  parameter int ADDR_W     = 32,
  parameter int SPAN_W     = 20,
  parameter int LINE_BYTES = 32
) (
  input  logic [ADDR_W-1:0] row_start,
  input  logic [SPAN_W-1:0] len_bytes,
  input  logic [ADDR_W-1:0] next_free,
  output logic [ADDR_W-1:0] first_line,
  output logic [ADDR_W-1:0] row_end,
  output logic              has_line
);
  localparam logic [ADDR_W-1:0] LINE_MASK = ADDR_W'(LINE_BYTES - 1);

  logic [ADDR_W-1:0] aligned;

  always_comb begin
    aligned    = row_start & ~LINE_MASK;
    // Clamp so a line shared with the previous row is not issued again.
    first_line = (aligned < next_free) ? next_free : aligned;
    row_end    = row_start + ADDR_W'(len_bytes);
    has_line   = first_line < row_end;
  end
endmodule

// File: rtl/cache_line_walker.sv
module cache_line_walker
  import wcw_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DIM_W      = 16,
  parameter int PSZ_W      = 3,
  parameter int LINE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cache_en,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [DIM_W-1:0]  width_px,
  input  logic [DIM_W-1:0]  skip_px,
  input  logic [DIM_W-1:0]  height_ln,
  input  logic [PSZ_W-1:0]  pix_bytes,
  output logic              line_valid,
  input  logic              line_ready,
  output logic [ADDR_W-1:0] line_addr,
  output logic              done,
  output logic              busy
);
  localparam int SPAN_W = DIM_W + 1 + PSZ_W;

  walk_state_t       state;
  logic [DIM_W-1:0]  cap_width;
  logic [DIM_W-1:0]  cap_skip;
  logic [PSZ_W-1:0]  cap_pix;
  logic [DIM_W-1:0]  rows_left;
  logic [ADDR_W-1:0] row_start;
  logic [ADDR_W-1:0] next_free;
  logic [ADDR_W-1:0] cur_line;
  logic [ADDR_W-1:0] cur_end;

  logic [SPAN_W-1:0] stride_bytes;
  logic [SPAN_W-1:0] len_bytes;
  logic [ADDR_W-1:0] plan_first;
  logic [ADDR_W-1:0] plan_end;
  logic              plan_has;

  logic              empty_job;
  logic              last_row;
  logic [ADDR_W-1:0] step_line;
  logic              row_over;

  wcw_geom #(
    .DIM_W (DIM_W),
    .PSZ_W (PSZ_W),
    .SPAN_W(SPAN_W)
  ) u_geom (
    .width_px    (cap_width),
    .skip_px     (cap_skip),
    .pix_bytes   (cap_pix),
    .stride_bytes(stride_bytes),
    .len_bytes   (len_bytes)
  );

  wcw_row_plan #(
    .ADDR_W    (ADDR_W),
    .SPAN_W    (SPAN_W),
    .LINE_BYTES(LINE_BYTES)
  ) u_plan (
    .row_start (row_start),
    .len_bytes (len_bytes),
    .next_free (next_free),
    .first_line(plan_first),
    .row_end   (plan_end),
    .has_line  (plan_has)
  );

  always_comb begin
    empty_job = !cache_en || (width_px == '0) || (height_ln == '0) || (pix_bytes == '0);
    last_row  = rows_left == DIM_W'(1);
    step_line = cur_line + ADDR_W'(LINE_BYTES);
    row_over  = !(step_line < cur_end);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= WS_IDLE;
      done      <= 1'b0;
      cap_width <= '0;
      cap_skip  <= '0;
      cap_pix   <= '0;
      rows_left <= '0;
      row_start <= '0;
      next_free <= '0;
      cur_line  <= '0;
      cur_end   <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        WS_IDLE: begin
          if (start) begin
            if (empty_job) begin
              done <= 1'b1;
            end else begin
              cap_width <= width_px;
              cap_skip  <= skip_px;
              cap_pix   <= pix_bytes;
              rows_left <= height_ln;
              row_start <= base_addr;
              next_free <= '0;
              state     <= WS_ROW;
            end
          end
        end
        WS_ROW: begin
          if (plan_has) begin
            cur_line <= plan_first;
            cur_end  <= plan_end;
            state    <= WS_EMIT;
          end else begin
            next_free <= plan_first;
            if (last_row) begin
              done  <= 1'b1;
              state <= WS_IDLE;
            end else begin
              rows_left <= rows_left - DIM_W'(1);
              row_start <= row_start + ADDR_W'(stride_bytes);
            end
          end
        end
        WS_EMIT: begin
          if (line_ready) begin
            if (!row_over) begin
              cur_line <= step_line;
            end else begin
              next_free <= step_line;
              if (last_row) begin
                done  <= 1'b1;
                state <= WS_IDLE;
              end else begin
                rows_left <= rows_left - DIM_W'(1);
                row_start <= row_start + ADDR_W'(stride_bytes);
                state     <= WS_ROW;
              end
            end
          end
        end
        default: state <= WS_IDLE;
      endcase
    end
  end

  assign line_valid = (state == WS_EMIT);
  assign line_addr  = cur_line;
  assign busy       = (state != WS_IDLE);
endmodule

// File: rtl/wcw_checker.sv
module wcw_checker #(
  parameter int ADDR_W     = 32,
  parameter int DIM_W      = 16,
  parameter int PSZ_W      = 3,
  parameter int LINE_BYTES = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              cache_en,
  input logic [DIM_W-1:0]  width_px,
  input logic [DIM_W-1:0]  height_ln,
  input logic [PSZ_W-1:0]  pix_bytes,
  input logic              line_valid,
  input logic              line_ready,
  input logic [ADDR_W-1:0] line_addr,
  input logic              done,
  input logic              busy
);
  logic              have_last;
  logic [ADDR_W-1:0] last_acc;
  logic              live_start;

  assign live_start = !busy && start && cache_en && (width_px != '0) &&
                      (height_ln != '0) && (pix_bytes != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_last <= 1'b0;
      last_acc  <= '0;
    end else if (!busy && start) begin
      have_last <= 1'b0;
    end else if (line_valid && line_ready) begin
      have_last <= 1'b1;
      last_acc  <= line_addr;
    end
  end

  // R1
  p_line_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |-> ((line_addr & ADDR_W'(LINE_BYTES - 1)) == '0));

  // R4
  p_strict_ascend_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (line_valid && have_last) |-> (line_addr > last_acc));

  // R5
  p_cache_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !cache_en) |=> (done && !busy));

  // R7
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (line_valid && !line_ready) |=> (line_valid && $stable(line_addr)));

  // R8
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !line_valid);

  // R10
  p_busy_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    live_start |=> busy);

  // R10
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind cache_line_walker wcw_checker #(
  .ADDR_W    (ADDR_W),
  .DIM_W     (DIM_W),
  .PSZ_W     (PSZ_W),
  .LINE_BYTES(LINE_BYTES)
) u_wcw_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .cache_en  (cache_en),
  .width_px  (width_px),
  .height_ln (height_ln),
  .pix_bytes (pix_bytes),
  .line_valid(line_valid),
  .line_ready(line_ready),
  .line_addr (line_addr),
  .done      (done),
  .busy      (busy)
);

// File: tb/test_cache_line_walker.sv
module test_cache_line_walker;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int DIM_W  = 16;
  localparam int PSZ_W  = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic              cache_en = 1'b1;
  logic [ADDR_W-1:0] base_addr = '0;
  logic [DIM_W-1:0]  width_px = '0;
  logic [DIM_W-1:0]  skip_px = '0;
  logic [DIM_W-1:0]  height_ln = '0;
  logic [PSZ_W-1:0]  pix_bytes = '0;
  logic              line_valid;
  logic              line_ready = 1'b0;
  logic [ADDR_W-1:0] line_addr;
  logic              done;
  logic              busy;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int hs_cyc = 0;
  int done_count = 0;
  int ready_mode = 0;
  logic [ADDR_W-1:0] exp_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  cache_line_walker i_cache_line_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .cache_en(cache_en),
    .base_addr(base_addr), .width_px(width_px), .skip_px(skip_px),
    .height_ln(height_ln), .pix_bytes(pix_bytes), .line_valid(line_valid),
    .line_ready(line_ready), .line_addr(line_addr), .done(done), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (done) done_count <= done_count + 1;
  end

  // Monitor: choose ready for the coming edge, then score the handshake it makes.
  always @(negedge clk) begin
    if (ready_mode == 0) line_ready = 1'b1;
    else line_ready = ($urandom % 3) != 0;
    if (rst_n && line_valid && line_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 unexpected address", line_addr, 0);
      end else begin
        logic [ADDR_W-1:0] e;
        e = exp_q.pop_front();
        check(line_addr == e, "R3 address order", line_addr, e);
      end
      hs_cyc = cyc;
    end
  end

  // Reference model built from R2, R3, R4 and R6.
  task automatic plan(input longint base, input longint w, input longint sk,
                      input longint h, input longint pb, input bit en, output bit tight);
    longint nf;
    nf = 0;
    tight = 0;
    if (!en || w == 0 || h == 0 || pb == 0) return;
    for (longint r = 0; r < h; r++) begin
      longint rs, re, a;
      bit emitted;
      rs = base + r * pb * (w + sk);
      re = rs + pb * w;
      a = rs & ~longint'(31);
      if (a < nf) a = nf;
      emitted = 0;
      while (a < re) begin
        exp_q.push_back(ADDR_W'(a));
        a += 32;
        emitted = 1;
      end
      nf = a;
      if (r == h - 1) tight = emitted;
    end
  endtask

  task automatic run_job(input longint base, input longint w, input longint sk,
                         input longint h, input longint pb, input bit en,
                         input bit poke_busy, input string tag);
    bit tight;
    bit empty;
    int d0;
    int guard;
    empty = !en || w == 0 || h == 0 || pb == 0;
    plan(base, w, sk, h, pb, en, tight);
    d0 = done_count;
    @(negedge clk);
    base_addr = ADDR_W'(base); width_px = DIM_W'(w); skip_px = DIM_W'(sk);
    height_ln = DIM_W'(h); pix_bytes = PSZ_W'(pb); cache_en = en;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    base_addr = 32'hDEAD_0000; width_px = 16'd999; height_ln = 16'd77;
    if (empty) begin
      check(done == 1'b1, {tag, " done after empty start"}, done, 1);
      check(busy == 1'b0, {tag, " busy stays low"}, busy, 0);
    end else begin
      check(busy == 1'b1, "R10 busy after start", busy, 1);
      if (poke_busy) begin
        @(negedge clk);
        base_addr = 32'h0000_8000; width_px = 16'd40; height_ln = 16'd9;
        pix_bytes = 3'd4; cache_en = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
      guard = 0;
      while (!done && guard < 5000) begin
        @(negedge clk);
        guard++;
      end
      check(done == 1'b1, {tag, " R7 done seen"}, done, 1);
      check(busy == 1'b0, "R10 busy low with done", busy, 0);
      if (tight) check(cyc == hs_cyc + 1, "R7 done right after last accept", cyc, hs_cyc + 1);
    end
    check(exp_q.size() == 0, {tag, " R7 all addresses accepted"}, exp_q.size(), 0);
    exp_q.delete();
    repeat (4) @(negedge clk);
    check(done_count == d0 + 1, {tag, " single done"}, done_count - d0, 1);
    check(busy == 1'b0 && line_valid == 1'b0, {tag, " R8 idle quiet"}, line_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(line_valid == 1'b0, "reset line_valid", line_valid, 0);
    check(done == 1'b0, "reset done", done, 0);
    check(busy == 1'b0, "reset busy", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);

    ready_mode = 0;
    run_job(64'h1000, 10, 6, 4, 2, 1, 0, "R2 stride rows");
    run_job(64'h2004, 5, 1, 6, 2, 1, 0, "R4 shared lines");
    run_job(64'h3010, 20, 4, 3, 4, 1, 0, "R3 multi-line rows");
    run_job(64'h401F, 33, 0, 2, 1, 1, 0, "R1 unaligned start");
    ready_mode = 1;
    run_job(64'h2004, 5, 1, 6, 2, 1, 0, "R8 stalls shared");
    run_job(64'h5008, 7, 50, 5, 3, 1, 0, "R8 stalls sparse");
    run_job(64'h6000, 1, 0, 40, 1, 1, 0, "R4 dense narrow");
    ready_mode = 0;
    run_job(64'h7000, 10, 6, 4, 2, 0, 0, "R5 cache off");
    run_job(64'h7000, 0, 6, 4, 2, 1, 0, "R6 zero width");
    run_job(64'h7000, 10, 6, 0, 2, 1, 0, "R6 zero height");
    run_job(64'h7000, 10, 6, 4, 0, 1, 0, "R6 zero pixel");
    ready_mode = 1;
    run_job(64'h1100, 16, 16, 5, 2, 1, 1, "R9 start while busy");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual %0d expected done earlier", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule